// File: doc/BRIEF.md
# Add-Then-Shift Bit-Column Compute Engine

This block is a single output-stationary compute engine for grouped integer weights kept in sign-magnitude form. At the start of a group it captures eight 8-bit two's-complement activations and the eight weight sign bits. Both stay in the engine for every column of that group. After that, each cycle it takes one magnitude bit-column: one bit per weight, all at the same significance. Every bit gates its activation, and the weight's sign decides whether the activation is negated. The eight products are summed, and the sum is shifted once by the column's significance and added into a signed accumulator.

The feeding logic sends only the non-zero columns of a group, each with its shift amount. It marks the first beat with a start strobe and the final beat with a last strobe. The start beat may carry the first column. The accumulator keeps its value until the next start. A one-cycle valid pulse marks the moment the group's final column has been folded in. Fetching operands and requantizing the result belong to neighbouring blocks.

Top module: `bcol_engine`

## Requirements
- R1: While reset is asserted and right after it is released, `psum_out` is 0 and `psum_valid` is 0.
- R2: Weight `g` occupies bits `[8g+7:8g]` of `act_in`, bit `g` of `sign_in` and bit `g` of `col_bits`. Its product is 0 when its column bit is 0. When the bit is 1, the product is the signed activation, negated when the sign bit is 1; an activation of -128 with sign 1 yields +128.
- R3: Each accepted column adds (sum of the eight products) multiplied by 2^`col_shift` to the accumulator.
- R4: A start beat clears the accumulator and loads `act_in` and `sign_in`. Those values are used for every column until the next start.
- R5: A start beat that also carries a column counts that column as the group's first.
- R6: When the beat carrying `col_valid` and `col_last` is sampled at edge E, `psum_valid` is high for exactly the cycle after edge E+2, and `psum_out` then holds the group's full sum.
- R7: On cycles with `col_valid` low, the accumulator does not change, whatever `col_bits` and `col_shift` carry. `psum_out` holds its value after the result until the next start.
- R8: A group sent as one start-and-last beat with all column bits 0 gives `psum_valid` with `psum_out` equal to 0.
- R9: The accumulator is 24 bits and wraps modulo 2^24. `psum_out` is read as two's complement.
- R10: `act_in` and `sign_in` are ignored on every beat where `start` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | First beat of a group: clear the accumulator, load activations and signs |
| act_in | input | 64 | Eight two's-complement activations, weight g at bits [8g+7:8g] |
| sign_in | input | 8 | Weight sign bits, 1 means negative |
| col_valid | input | 1 | A magnitude column is present on this beat |
| col_bits | input | 8 | One magnitude bit per weight at the current significance |
| col_shift | input | 3 | Significance of the column (left shift amount) |
| col_last | input | 1 | This column is the group's final one |
| psum_out | output | 24 | Accumulated partial sum, two's complement |
| psum_valid | output | 1 | One-cycle pulse when the group's sum is complete |

## Verification
A product with the wrong sign or gate, or a shift applied before the sum rather than after it, changes `psum_out` in the cycle the result is flagged. That is three edges after the final column. Stale activations from an earlier group, or a column that leaked through while `col_valid` was low, show up the same way. These faults appear in the very next group's result, because the bench changes `act_in` and `sign_in` on every non-start beat and drives random bits during gaps. A pipeline flag lost or duplicated between stages shows as a valid pulse one cycle off or doubled. A start that fails to clear the accumulator shows up in the next group's sum, and it is most visible in the all-zero group.

// File: rtl/bcol_engine.sv
`timescale 1ns/1ps
module bcol_engine #(
  parameter int GROUP   = 8,
  parameter int ACT_W   = 8,
  parameter int SHIFT_W = 3,
  parameter int ACC_W   = 24
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [GROUP*ACT_W-1:0]   act_in,
  input  logic [GROUP-1:0]         sign_in,
  input  logic                     col_valid,
  input  logic [GROUP-1:0]         col_bits,
  input  logic [SHIFT_W-1:0]       col_shift,
  input  logic                     col_last,
  output logic [ACC_W-1:0]         psum_out,
  output logic                     psum_valid
);
  localparam int PROD_W = ACT_W + 1;
  localparam int SUM_W  = PROD_W + $clog2(GROUP);

  logic [GROUP*ACT_W-1:0] act_q;
  logic [GROUP-1:0]       sign_q;

  logic [GROUP-1:0]       s1_bits;
  logic [SHIFT_W-1:0]     s1_shift;
  logic                   s1_v, s1_last;

  logic signed [SUM_W-1:0] s2_sum;
  logic [SHIFT_W-1:0]      s2_shift;
  logic                    s2_v, s2_last;

  logic signed [SUM_W-1:0] prod [GROUP];
  logic signed [SUM_W-1:0] col_sum;
  logic [ACC_W-1:0]        acc;
  logic [ACC_W-1:0]        shifted;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= '0;
      sign_q <= '0;
    end else if (start) begin
      act_q  <= act_in;
      sign_q <= sign_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_bits  <= '0;
      s1_shift <= '0;
      s1_v     <= 1'b0;
      s1_last  <= 1'b0;
    end else begin
      s1_bits  <= col_valid ? col_bits : '0;
      s1_shift <= col_shift;
      s1_v     <= col_valid;
      s1_last  <= col_valid & col_last;
    end
  end

  for (genvar g = 0; g < GROUP; g++) begin : g_mul
    logic signed [SUM_W-1:0] a_ext;
    assign a_ext   = SUM_W'($signed(act_q[g*ACT_W +: ACT_W]));
    assign prod[g] = !s1_bits[g] ? '0 : (sign_q[g] ? -a_ext : a_ext);
  end

  always_comb begin
    col_sum = '0;
    for (int g = 0; g < GROUP; g++) col_sum = col_sum + prod[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_sum   <= '0;
      s2_shift <= '0;
      s2_v     <= 1'b0;
      s2_last  <= 1'b0;
    end else begin
      s2_sum   <= col_sum;
      s2_shift <= s1_shift;
      s2_v     <= s1_v;
      s2_last  <= s1_last;
    end
  end

  assign shifted = ACC_W'(s2_sum) << s2_shift;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc        <= '0;
      psum_valid <= 1'b0;
    end else begin
      if (start)     acc <= '0;
      else if (s2_v) acc <= acc + shifted;
      psum_valid <= s2_v & s2_last;
    end
  end

  assign psum_out = acc;
endmodule

module bcol_engine_chk #(
  parameter int GROUP = 8,
  parameter int ACC_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             col_valid,
  input logic [GROUP-1:0] col_bits,
  input logic             col_last,
  input logic [ACC_W-1:0] psum_out,
  input logic             psum_valid
);
  logic v1, v2, z1, z2, l1, l2, l3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {v1, v2, z1, z2, l1, l2, l3} <= '0;
    end else begin
      v1 <= col_valid;
      v2 <= v1;
      z1 <= col_valid && (col_bits == '0);
      z2 <= z1;
      l1 <= col_valid && col_last;
      l2 <= l1;
      l3 <= l2;
    end
  end

  // R6: valid pulse three edges after the last column
  p_valid_timing_r6: assert property (@(posedge clk) disable iff (!rst_n)
    psum_valid == l3);

  // R4: start clears the accumulator
  p_start_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> psum_out == '0);

  // R7: nothing accepted, nothing changes
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!v2 && !start) |=> $stable(psum_out));

  // R8: an all-zero column adds nothing
  p_zero_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (v2 && z2 && !start) |=> $stable(psum_out));
endmodule

bind bcol_engine bcol_engine_chk #(.GROUP(GROUP), .ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .col_valid(col_valid),
  .col_bits(col_bits), .col_last(col_last), .psum_out(psum_out),
  .psum_valid(psum_valid)
);

// File: tb/bcol_engine_test.sv
`timescale 1ns/1ps
module bcol_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] act_in = '0;
  logic [7:0]  sign_in = '0;
  logic        col_valid = 1'b0;
  logic [7:0]  col_bits = '0;
  logic [2:0]  col_shift = '0;
  logic        col_last = 1'b0;
  logic [23:0] psum_out;
  logic        psum_valid;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [7:0] cb [0:127];
  logic [2:0] cs [0:127];

  bcol_engine uut (
    .clk(clk), .rst_n(rst_n), .start(start), .act_in(act_in), .sign_in(sign_in),
    .col_valid(col_valid), .col_bits(col_bits), .col_shift(col_shift),
    .col_last(col_last), .psum_out(psum_out), .psum_valid(psum_valid)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", cyc, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic longint col_sum(input logic [63:0] acts, input logic [7:0] sg,
                                     input logic [7:0] bits);
    longint s = 0;
    for (int g = 0; g < 8; g++) begin
      longint a = longint'($signed(acts[g*8 +: 8]));
      if (bits[g]) s += sg[g] ? -a : a;
    end
    return s;
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic drive_idle();
    start     = 1'b0;
    col_valid = 1'b0;
    col_last  = 1'b0;
    col_bits  = 8'($urandom);
    col_shift = 3'($urandom);
    act_in    = {$urandom, $urandom};
    sign_in   = 8'($urandom);
  endtask

  task automatic run_group(input string tag, input logic [63:0] acts,
                           input logic [7:0] sg, input int n, input bit gaps);
    longint exp = 0;
    longint held;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (gaps && i > 0 && ($urandom % 3) == 0) begin
        drive_idle();
        @(negedge clk);
      end
      start     = (i == 0);
      act_in    = (i == 0) ? acts : {$urandom, $urandom};
      sign_in   = (i == 0) ? sg : 8'($urandom);
      col_valid = 1'b1;
      col_bits  = cb[i];
      col_shift = cs[i];
      col_last  = (i == n - 1);
      exp += col_sum(acts, sg, cb[i]) <<< cs[i];
    end
    @(negedge clk);
    drive_idle();
    @(negedge clk);
    chk({tag, " R6 early"}, longint'(psum_valid), 0);
    @(negedge clk);
    chk({tag, " R6 valid"}, longint'(psum_valid), 1);
    chk(tag, longint'(psum_out), exp & 64'hFFFFFF);
    held = longint'(psum_out);
    @(negedge clk);
    chk({tag, " R6 pulse"}, longint'(psum_valid), 0);
    @(negedge clk);
    chk({tag, " R7 hold"}, longint'(psum_out), held);
  endtask

  initial begin
    logic [63:0] acts;
    void'($urandom(32'h1357_2468));
    #1;
    chk("R1 in reset out", longint'(psum_out), 0);
    chk("R1 in reset valid", longint'(psum_valid), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset out", longint'(psum_out), 0);
    chk("R1 after reset valid", longint'(psum_valid), 0);

    acts = {8'd8, -8'sd7, 8'd6, -8'sd5, 8'd4, 8'd3, -8'sd2, 8'd1};
    cb[0] = 8'hFF; cs[0] = 3'd0;
    run_group("R2 mixed signs R5", acts, 8'b1010_0101, 1, 1'b0);

    cb[0] = 8'hFF; cs[0] = 3'd0;
    run_group("R2 minus128 negated", {8{8'h80}}, 8'hFF, 1, 1'b0);

    cb[0] = 8'b0101_0011; cs[0] = 3'd0;
    run_group("R2 gated bits", acts, 8'h0F, 1, 1'b0);

    cb[0] = 8'h01; cs[0] = 3'd6;
    cb[1] = 8'h01; cs[1] = 3'd1;
    run_group("R3 shift after sum", {8{8'd1}}, 8'h00, 2, 1'b0);

    cb[0] = 8'h00; cs[0] = 3'd5;
    run_group("R8 R4 zero group", {8{8'd100}}, 8'h00, 1, 1'b0);

    for (int i = 0; i < 70; i++) begin cb[i] = 8'hFF; cs[i] = 3'd7; end
    run_group("R9 wrap", {8{8'd127}}, 8'h00, 70, 1'b0);

    for (int i = 0; i < 70; i++) begin cb[i] = 8'hFF; cs[i] = 3'd7; end
    run_group("R9 wrap negative", {8{8'h80}}, 8'h00, 70, 1'b0);

    for (int k = 0; k < 40; k++) begin
      int n = 1 + int'($urandom % 12);
      for (int i = 0; i < n; i++) begin
        cb[i] = 8'($urandom);
        cs[i] = 3'($urandom % 7);
      end
      run_group("R3 R4 R7 R10 random", {$urandom, $urandom}, 8'($urandom), n, 1'b1);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule